// File: doc/BRIEF.md
# Cell-Level Utopia Transmit Master

This block sends ATM cells to the transmit port of one Utopia Level 2 slave. It uses the cell-level handshake on an 8-bit data bus. On the local side, bytes arrive through a valid/ready interface, and a start-of-cell flag marks the first byte of each cell. The bytes are framed into cells and held in an internal byte buffer. A cell is offered to the slave only once every byte of that cell is stored, so a cell never stalls halfway because the local source ran dry.

On the Utopia side, the block watches the slave's cell-available flag. It drives the byte, a parity bit, a start-of-cell pulse and an active-low enable, all from registers. Cells go back to back with no idle cycle whenever the slave still reports room and another full cell is buffered. The cell length is a static byte count taken from a configuration input, valid from 16 to 128. The buffer depth and the parity sense (odd by default) are parameters.

Top module: `utx_cell_master`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `tx_enb_n` is 1, `tx_soc` is 0 and `src_ready` is 1.
- R2: A cell starts only at a clock edge where `tx_clav` is 1 and at least one complete cell is buffered, counting cells completed before that edge. The first byte appears after that edge with `tx_soc`=1 and `tx_enb_n`=0.
- R3: Every cell has exactly `cfg_cell_len` consecutive cycles with `tx_enb_n`=0. `tx_soc` is 1 only on the first of them, and the enable never rises inside a cell.
- R4: At the edge that ends the last byte of a cell, if `tx_clav` is 1 and another complete cell is buffered, the next cycle carries that cell's first byte with `tx_soc`=1. `tx_enb_n` stays 0 throughout.
- R5: If `tx_clav` is 0 at the edge that ends the last byte of a cell, `tx_enb_n` goes to 1 in the next cycle and stays 1 until R2 is met again.
- R6: In every cycle with `tx_enb_n`=0, `tx_data` and `tx_prty` together hold an odd number of ones when `ODD_PARITY`=1, and an even number when it is 0.
- R7: The bytes kept by the local side are sent in the order they were accepted, with none lost or repeated.
- R8: A byte accepted at cell position 0 with `src_soc`=0 is discarded. A byte with `src_soc`=1 at any later position is kept as ordinary data.
- R9: `src_ready` is 0 exactly when `DEPTH` bytes are buffered. No byte is taken while it is 0.
- R10: A cell that completes on the local side at the same edge as a cell start on the Utopia side is still counted. It is sent next.
- R11: Any `cfg_cell_len` from 16 to 128 sets the cell length, held stable while out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cell_len | input | 8 | Static cell length in bytes (16..128) |
| src_valid | input | 1 | Local byte offered |
| src_soc | input | 1 | Local byte is the first of a cell |
| src_data | input | 8 | Local byte |
| src_ready | output | 1 | Buffer can take a byte this cycle |
| tx_clav | input | 1 | Slave can accept a whole cell |
| tx_data | output | 8 | Utopia transmit byte |
| tx_prty | output | 1 | Parity of `tx_data` |
| tx_soc | output | 1 | First byte of a cell |
| tx_enb_n | output | 1 | Active-low transfer enable |

## Verification
Two events can land on the same clock edge: the local side finishing a cell, and the Utopia side committing a cell, whether from idle or at a cell boundary. Both update the count of buffered complete cells. A directed case holds `tx_clav` low until one cell is stored, then feeds the last byte of a second cell in the very cycle the flag rises. That second cell must follow the first with no gap. A per-cycle behavioural model also compares enable, start-of-cell, data, parity and `src_ready` while `tx_clav` toggles at random and the local bytes arrive in uneven bursts, so such coincidences recur many times.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int UTX_DW       = 8;
    localparam int UTX_LEN_W    = 8;
    localparam int UTX_MIN_CELL = 16;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // Registered Utopia transmit bundle
    typedef struct packed {
        logic              enb_n;
        logic              soc;
        logic              prty;
        logic [UTX_DW-1:0] data;
    } utx_bus_t;

    function automatic logic par_bit(input logic [UTX_DW-1:0] d, input bit odd);
        return odd ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/utx_ingest.sv
// Frames local bytes into cells: aligns on start-of-cell, flags completion.
module utx_ingest
    import utx_pkg::*;
#(
    parameter int LEN_W = UTX_LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic             buf_full,
    output logic             in_ready,
    output logic             wr_en,
    output logic             cell_done
);

    logic [LEN_W-1:0] pos_q;
    logic             accept;
    logic             keep;
    logic             last;

    assign in_ready  = !buf_full;
    assign accept    = in_valid && !buf_full;
    // position 0 demands a start marker; later markers are plain data
    assign keep      = accept && ((pos_q != '0) || in_soc);
    assign last      = keep && (pos_q == cfg_len - LEN_W'(1));
    assign wr_en     = keep;
    assign cell_done = last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (keep) begin
            pos_q <= last ? '0 : pos_q + LEN_W'(1);
        end
    end

    // R8: a kept byte at position 0 always carried the start marker
    a_r8_align_on_soc: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pos_q == '0) |-> in_soc);

endmodule

// File: rtl/utx_byte_fifo.sv
// Byte store between the framing side and the Utopia side.
module utx_byte_fifo
    import utx_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = UTX_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [PTR_W:0]   cnt_q;

    assign full    = (cnt_q == FULL_CNT);
    assign empty   = (cnt_q == '0);
    assign rd_data = mem[rp_q];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wp_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wp_q <= wp_q + PTR_W'(1);
            if (rd_en) rp_q <= rp_q + PTR_W'(1);
            case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + (PTR_W+1)'(1);
                2'b01:   cnt_q <= cnt_q - (PTR_W+1)'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    a_r9_no_push_full: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);

endmodule

// File: rtl/utx_tx_ctrl.sv
// Utopia-side sequencer: cell commit, byte walk, back-to-back decision.
module utx_tx_ctrl
    import utx_pkg::*;
#(
    parameter int LEN_W      = UTX_LEN_W,
    parameter int CELLS_W    = 5,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cell_done,
    input  logic              tx_clav,
    input  logic [UTX_DW-1:0] rd_data,
    output logic              rd_en,
    output logic [UTX_DW-1:0] tx_data,
    output logic              tx_prty,
    output logic              tx_soc,
    output logic              tx_enb_n
);

    tx_state_e        state_q;
    logic [LEN_W-1:0] pos_q;
    logic [CELLS_W-1:0] cells_q;
    utx_bus_t         bus_q;

    logic at_end;
    logic may_start;
    logic advance;

    assign at_end    = (state_q == TX_SEND) && (pos_q == cfg_len - LEN_W'(1));
    assign may_start = tx_clav && (cells_q != '0) && ((state_q == TX_IDLE) || at_end);
    assign advance   = (state_q == TX_SEND) && !at_end;
    assign rd_en     = may_start || advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q <= '0;
        end else begin
            cells_q <= cells_q + CELLS_W'(cell_done) - CELLS_W'(may_start);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= TX_IDLE;
            pos_q      <= '0;
            bus_q.enb_n <= 1'b1;
            bus_q.soc  <= 1'b0;
            bus_q.data <= '0;
            bus_q.prty <= par_bit('0, ODD_PARITY);
        end else if (may_start) begin
            state_q    <= TX_SEND;
            pos_q      <= '0;
            bus_q.enb_n <= 1'b0;
            bus_q.soc  <= 1'b1;
            bus_q.data <= rd_data;
            bus_q.prty <= par_bit(rd_data, ODD_PARITY);
        end else if (advance) begin
            pos_q      <= pos_q + LEN_W'(1);
            bus_q.soc  <= 1'b0;
            bus_q.data <= rd_data;
            bus_q.prty <= par_bit(rd_data, ODD_PARITY);
        end else begin
            state_q    <= TX_IDLE;
            pos_q      <= '0;
            bus_q.enb_n <= 1'b1;
            bus_q.soc  <= 1'b0;
        end
    end

    assign tx_data  = bus_q.data;
    assign tx_prty  = bus_q.prty;
    assign tx_soc   = bus_q.soc;
    assign tx_enb_n = bus_q.enb_n;

    a_r3_soc_needs_enb: assert property (@(posedge clk) disable iff (rst)
        tx_soc |-> !tx_enb_n);
    a_r3_soc_single: assert property (@(posedge clk) disable iff (rst)
        tx_soc |=> !tx_soc);
    a_r3_no_midcell_gap: assert property (@(posedge clk) disable iff (rst)
        (!tx_enb_n && !at_end) |=> !tx_enb_n);
    a_r2_start_needs_clav: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_enb_n) |-> $past(tx_clav));
    a_r5_stop_without_clav: assert property (@(posedge clk) disable iff (rst)
        (at_end && !tx_clav) |=> tx_enb_n);
    a_r6_parity: assert property (@(posedge clk) disable iff (rst)
        !tx_enb_n |-> ((^{tx_data, tx_prty}) == ODD_PARITY));

endmodule

// File: rtl/utx_cell_master.sv
module utx_cell_master
    import utx_pkg::*;
#(
    parameter int DEPTH      = 256,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [UTX_LEN_W-1:0] cfg_cell_len,
    input  logic                 src_valid,
    input  logic                 src_soc,
    input  logic [UTX_DW-1:0]    src_data,
    output logic                 src_ready,
    input  logic                 tx_clav,
    output logic [UTX_DW-1:0]    tx_data,
    output logic                 tx_prty,
    output logic                 tx_soc,
    output logic                 tx_enb_n
);

    localparam int CELLS_W = $clog2(DEPTH / UTX_MIN_CELL + 1);

    logic              wr_en;
    logic              cell_done;
    logic              rd_en;
    logic [UTX_DW-1:0] rd_data;
    logic              buf_full;
    logic              buf_empty;

    utx_ingest #(.LEN_W(UTX_LEN_W)) u_ingest (
        .clk       (clk),
        .rst       (rst),
        .cfg_len   (cfg_cell_len),
        .in_valid  (src_valid),
        .in_soc    (src_soc),
        .buf_full  (buf_full),
        .in_ready  (src_ready),
        .wr_en     (wr_en),
        .cell_done (cell_done)
    );

    utx_byte_fifo #(.DEPTH(DEPTH), .DW(UTX_DW)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (src_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .full    (buf_full),
        .empty   (buf_empty)
    );

    utx_tx_ctrl #(
        .LEN_W      (UTX_LEN_W),
        .CELLS_W    (CELLS_W),
        .ODD_PARITY (ODD_PARITY)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .cfg_len   (cfg_cell_len),
        .cell_done (cell_done),
        .tx_clav   (tx_clav),
        .rd_data   (rd_data),
        .rd_en     (rd_en),
        .tx_data   (tx_data),
        .tx_prty   (tx_prty),
        .tx_soc    (tx_soc),
        .tx_enb_n  (tx_enb_n)
    );

    // R9: a full buffer never reports readiness
    a_r9_ready_vs_full: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> !src_ready);

endmodule

// File: tb/utx_cell_master_tb.sv
module utx_cell_master_tb;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_cell_len = 8'd16;
    logic       src_valid = 1'b0;
    logic       src_soc = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_ready;
    logic       tx_clav = 1'b0;
    logic [7:0] tx_data;
    logic       tx_prty;
    logic       tx_soc;
    logic       tx_enb_n;

    always #5 clk = ~clk;

    utx_cell_master #(.DEPTH(DEPTH), .ODD_PARITY(1'b1)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_cell_len (cfg_cell_len),
        .src_valid    (src_valid),
        .src_soc      (src_soc),
        .src_data     (src_data),
        .src_ready    (src_ready),
        .tx_clav      (tx_clav),
        .tx_data      (tx_data),
        .tx_prty      (tx_prty),
        .tx_soc       (tx_soc),
        .tx_enb_n     (tx_enb_n)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;
    bit rand_clav = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_q[$];
    int   m_in_pos;
    int   m_cells;
    bit   m_active;
    int   m_pos;
    bit   m_soc;
    bit   m_enb_n;
    logic [7:0] m_data;
    int   m_len;
    bit   m_acc;
    bit   m_end;

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_in_pos = 0; m_cells = 0; m_active = 0; m_pos = 0;
            m_soc = 0; m_enb_n = 1; m_data = 8'h00;
        end else begin
            m_len = int'(cfg_cell_len);
            m_acc = src_valid && (m_q.size() < DEPTH);
            m_end = m_active && (m_pos == m_len - 1);
            if (m_active && !m_end) begin
                m_pos++;
                m_data = m_q.pop_front();
                m_soc = 0;
            end else if (tx_clav && m_cells > 0) begin
                m_data = m_q.pop_front();
                m_soc = 1; m_pos = 0; m_active = 1; m_enb_n = 0;
                m_cells--;
            end else begin
                m_active = 0; m_soc = 0; m_enb_n = 1; m_pos = 0;
            end
            if (m_acc && (m_in_pos != 0 || src_soc)) begin
                m_q.push_back(src_data);
                m_in_pos++;
                if (m_in_pos == m_len) begin
                    m_in_pos = 0;
                    m_cells++;
                end
            end
        end
    end

    // ---------------- per-cycle comparison and monitors ----------------
    int soc_cnt = 0;
    int low_cnt = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R3 enable", tx_enb_n, m_enb_n);
            chk("R3 start-of-cell", tx_soc, m_soc);
            chk("R9 ready", src_ready, (m_q.size() < DEPTH));
            if (!tx_enb_n) begin
                chk("R7 data", tx_data, m_data);
                chk("R6 parity", ^{tx_data, tx_prty}, 1'b1);
                low_cnt++;
            end
            if (tx_soc) soc_cnt++;
        end
    end

    always @(negedge clk) begin
        if (rand_clav) tx_clav = (($urandom % 10) < 7);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset(input logic [7:0] len);
        @(negedge clk);
        rst = 1; cfg_cell_len = len; tx_clav = 0; src_valid = 0; src_soc = 0;
        repeat (3) @(negedge clk);
        chk("R1 enable in reset", tx_enb_n, 1'b1);
        chk("R1 soc in reset", tx_soc, 1'b0);
        chk("R1 ready in reset", src_ready, 1'b1);
        rst = 0;
        @(negedge clk);
        chk("R1 enable after reset", tx_enb_n, 1'b1);
        chk("R1 soc after reset", tx_soc, 1'b0);
        soc_cnt = 0; low_cnt = 0;
    endtask

    task automatic send_byte(input logic soc, input logic [7:0] d);
        @(negedge clk);
        while (!src_ready) begin
            src_valid = 0;
            @(negedge clk);
        end
        src_valid = 1; src_soc = soc; src_data = d;
    endtask

    task automatic src_idle();
        @(negedge clk);
        src_valid = 0; src_soc = 0;
    endtask

    task automatic send_cell(input int len);
        for (int i = 0; i < len; i++) send_byte(i == 0, 8'($urandom));
    endtask

    // ---------------- scenarios ----------------
    initial begin
        // R2/R4: three cells fed with the flag high go out back to back
        do_reset(8'd16);
        tx_clav = 1;
        repeat (3) send_cell(16);
        src_idle();
        repeat (40) @(negedge clk);
        chk("R4 three cells sent", soc_cnt, 3);
        chk("R3 bytes on bus", low_cnt, 48);

        // R5: flag high for one edge only, one cell then stop
        do_reset(8'd16);
        repeat (3) send_cell(16);
        src_idle();
        @(negedge clk); tx_clav = 1;
        @(negedge clk); tx_clav = 0;
        repeat (30) @(negedge clk);
        chk("R5 stopped after one cell", soc_cnt, 1);
        chk("R5 enable high", tx_enb_n, 1'b1);
        tx_clav = 1;
        repeat (40) @(negedge clk);
        chk("R4 remaining two cells", soc_cnt, 3);
        chk("R3 total bytes", low_cnt, 48);

        // R8: stray bytes dropped, mid-cell marker kept as data
        do_reset(8'd16);
        tx_clav = 1;
        send_byte(0, 8'hAA);
        send_byte(0, 8'hBB);
        for (int i = 0; i < 16; i++) send_byte(i == 0 || i == 5, 8'(i + 8'h40));
        src_idle();
        repeat (30) @(negedge clk);
        chk("R8 exactly one cell", soc_cnt, 1);
        chk("R8 cell length kept", low_cnt, 16);

        // R10: local completion and Utopia commit on the same edge
        do_reset(8'd16);
        send_cell(16);
        for (int i = 0; i < 15; i++) send_byte(i == 0, 8'($urandom));
        @(negedge clk);
        src_valid = 1; src_soc = 0; src_data = 8'h5C; tx_clav = 1;
        src_idle();
        repeat (40) @(negedge clk);
        chk("R10 second cell counted", soc_cnt, 2);
        chk("R4 no gap between cells", low_cnt, 32);

        // R9/R11: longest cell fills the buffer exactly
        do_reset(8'd128);
        send_cell(128);
        send_cell(128);
        src_idle();
        @(negedge clk);
        chk("R9 ready low when full", src_ready, 1'b0);
        src_valid = 1; src_soc = 1; src_data = 8'hEE;
        repeat (3) @(negedge clk);
        chk("R9 still not ready", src_ready, 1'b0);
        src_valid = 0; src_soc = 0;
        tx_clav = 1;
        repeat (270) @(negedge clk);
        chk("R11 two long cells", soc_cnt, 2);
        chk("R11 long cell bytes", low_cnt, 256);

        // R11/R7: 53-byte cells, random flag, uneven bursts, stray bytes
        do_reset(8'd53);
        rand_clav = 1;
        for (int c = 0; c < 20; c++) begin
            for (int j = 0; j < int'($urandom % 3); j++) send_byte(0, 8'($urandom));
            for (int i = 0; i < 53; i++) begin
                send_byte(i == 0 || (($urandom % 16) == 0), 8'($urandom));
                if (($urandom % 4) == 0) src_idle();
            end
        end
        src_idle();
        rand_clav = 0;
        @(negedge clk);
        tx_clav = 1;
        repeat (400) @(negedge clk);
        chk("R7 all cells delivered", soc_cnt, 20);
        chk("R11 53-byte cells", low_cnt, 20 * 53);
        chk("R5 idle after drain", tx_enb_n, 1'b1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule